// File: doc/BRIEF.md
# Mode-Configurable Triple Line Memory

This block holds three equal memory banks, the middle one built as two nibble-wide halves, and lets a static 3-bit mode input regroup them into eight arrangements. The arrangements are three separate byte channels, delay chains in which one channel's read stream feeds the next bank, 12-bit channels formed by lending each byte bank a nibble of the middle bank, and long channels made by joining two or three banks end to end. Every channel is a line memory. A write pointer stores words and a read pointer replays them. Each pointer has its own enable and its own clear, and there are no full or empty flags. Line delays come from how the pointers are reset relative to each other.

The block is used as a video or signal line-delay store inside a larger chip. The pad ring turns the per-lane output enables into tri-state drivers. The mode acts as a static state: it is set while `rst_n` is low and held afterwards, and there are no transitions between modes at run time. The eight states are MODE_SPLIT3, MODE_CHAIN3, MODE_CHAIN2_SPLIT1, MODE_WIDE2, MODE_WIDE_CHAIN, MODE_DEEP3, MODE_DEEP2_SPLIT1 and MODE_WIDE_DEEP. Everything runs on one clock.

Top module: `tri_field_mem`

## Requirements
- R1: `mode_sel` selects the modes in binary order: 000 SPLIT3, 001 CHAIN3, 010 CHAIN2_SPLIT1, 011 WIDE2, 100 WIDE_CHAIN, 101 DEEP3, 110 DEEP2_SPLIT1, 111 WIDE_DEEP.
- R2: In a channel's write set, `wr_rst` high clears the write pointer and stores nothing. Otherwise `wr_en` high stores the channel's input word at the write pointer and advances the pointer. Index 0 of `wr_en`, `wr_rst`, `rd_en` and `rd_rst` is set A, index 1 is set B and index 2 is set C.
- R3: In a read set, `rd_rst` high clears the read pointer. Otherwise `rd_en` high makes the word at the read pointer appear on the channel's lanes one cycle later, with their `lane_oe` bits high, and advances the pointer. Otherwise the lanes' `lane_oe` bits go low on the next cycle and the pointer holds.
- R4: The pointers wrap to 0 after the last word of a line. The line is DEPTH words in modes SPLIT3 to WIDE_CHAIN and for channel C of DEEP2_SPLIT1, 3*DEPTH in DEEP3, and 2*DEPTH for the A channel of DEEP2_SPLIT1 and WIDE_DEEP.
- R5: In SPLIT3, sets A, B and C drive three independent byte channels: `din_a` to `dout_a`, `din_b` to `dout_b`, and `din_c` to `dout_c`.
- R6: In CHAIN3, CHAIN2_SPLIT1 and WIDE_CHAIN, a downstream stage is driven only by read set A. It outputs the word that its upstream stage output at the same line position one line earlier. Set B, and in CHAIN3 set C, have no effect.
- R7: In WIDE2, WIDE_CHAIN and WIDE_DEEP, the first 12-bit channel is {`din_a`, `din_b[3:0]`} in and {`dout_a`, `dout_b[3:0]`} out. The second is {`din_c`, `din_b[7:4]`} in and {`dout_c`, `dout_b[7:4]`} out. The byte bus carries bits 11:4 in each case.
- R8: DEEP3, DEEP2_SPLIT1 and WIDE_DEEP join banks into one channel on set A. Consecutive words fill bank after bank, and words read back in write order across the bank boundaries.
- R9: `lane_oe` bit 0 is `dout_a`, bit 1 is `dout_b[3:0]`, bit 2 is `dout_b[7:4]` and bit 3 is `dout_c`. Lanes with no channel stay low: bits 3:1 in DEEP3, bits 2:1 in DEEP2_SPLIT1, and bits 3:2 in WIDE_DEEP.
- R10: While `rst_n` is low, all pointers clear and `lane_oe` is 0.
- R11: When a channel reads and writes the same position in one cycle, the read returns the word stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all banks and pointers |
| rst_n | input | 1 | Active-low asynchronous reset of pointers and lane enables |
| mode_sel | input | 3 | Static configuration select |
| wr_en | input | 3 | Write enables, sets A/B/C at bits 0/1/2 |
| wr_rst | input | 3 | Write pointer clears, sets A/B/C |
| rd_en | input | 3 | Read enables, sets A/B/C |
| rd_rst | input | 3 | Read pointer clears, sets A/B/C |
| din_a | input | 8 | Input bus A |
| din_b | input | 8 | Input bus B (nibbles lent to the 12-bit channels) |
| din_c | input | 8 | Input bus C |
| dout_a | output | 8 | Output bus A |
| dout_b | output | 8 | Output bus B |
| dout_c | output | 8 | Output bus C |
| lane_oe | output | 4 | Output drive enables per lane |

## Verification
The hardest situation to reach is a chained mode in which a downstream stage returns a line that is both fully written and correctly aligned. This needs a full line of upstream reads first, and every read-pointer clear of set A shifts the alignment. The stimulus runs each chained mode for many lines. It uses random read enables and clears and randomises the unused B and C controls. A bench model tracks, per position, whether a word has really been stored, so that every data comparison is made on a known word and data-lane compares are skipped only while a position still holds nothing.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
    typedef enum logic [2:0] {
        MODE_SPLIT3        = 3'd0,
        MODE_CHAIN3        = 3'd1,
        MODE_CHAIN2_SPLIT1 = 3'd2,
        MODE_WIDE2         = 3'd3,
        MODE_WIDE_CHAIN    = 3'd4,
        MODE_DEEP3         = 3'd5,
        MODE_DEEP2_SPLIT1  = 3'd6,
        MODE_WIDE_DEEP     = 3'd7
    } tfm_mode_e;
endpackage

// File: rtl/tfm_ptr.sv
module tfm_ptr #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [PW-1:0] last,
    output logic [PW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= '0;
        else if (clr)     ptr <= '0;
        else if (adv)     ptr <= (ptr == last) ? '0 : ptr + PW'(1);
    end

    p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= last);
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && ptr == last) |=> ptr == '0);
    p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ptr == '0);
endmodule

// File: rtl/tfm_slice.sv
module tfm_slice #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata      <= mem[raddr];
    end
endmodule

// File: rtl/tri_field_mem.sv
module tri_field_mem
    import tfm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_sel,
    input  logic [2:0]    wr_en,
    input  logic [2:0]    wr_rst,
    input  logic [2:0]    rd_en,
    input  logic [2:0]    rd_rst,
    input  logic [BW-1:0] din_a,
    input  logic [BW-1:0] din_b,
    input  logic [BW-1:0] din_c,
    output logic [BW-1:0] dout_a,
    output logic [BW-1:0] dout_b,
    output logic [BW-1:0] dout_c,
    output logic [3:0]    lane_oe
);
    localparam int HW = BW / 2;
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 2;

    tfm_mode_e mode;
    assign mode = tfm_mode_e'(mode_sel);

    logic [2:0] wfire, rfire;
    assign wfire = wr_en & ~wr_rst;
    assign rfire = rd_en & ~rd_rst;

    // set A pointers span up to three banks; sets B and C span one
    logic [PW-1:0] wp0, rp0, last0;
    logic [AW-1:0] wp_bc [2];
    logic [AW-1:0] rp_bc [2];

    always_comb begin
        unique case (mode)
            MODE_DEEP3:                         last0 = PW'(3*DEPTH-1);
            MODE_DEEP2_SPLIT1, MODE_WIDE_DEEP:  last0 = PW'(2*DEPTH-1);
            default:                            last0 = PW'(DEPTH-1);
        endcase
    end

    tfm_ptr #(.PW(PW)) u_wp0 (.clk(clk), .rst_n(rst_n), .clr(wr_rst[0]),
        .adv(wfire[0]), .last(last0), .ptr(wp0));
    tfm_ptr #(.PW(PW)) u_rp0 (.clk(clk), .rst_n(rst_n), .clr(rd_rst[0]),
        .adv(rfire[0]), .last(last0), .ptr(rp0));

    for (genvar ch = 1; ch < 3; ch++) begin : g_bc_ptr
        tfm_ptr #(.PW(AW)) u_wp (.clk(clk), .rst_n(rst_n), .clr(wr_rst[ch]),
            .adv(wfire[ch]), .last(AW'(DEPTH-1)), .ptr(wp_bc[ch-1]));
        tfm_ptr #(.PW(AW)) u_rp (.clk(clk), .rst_n(rst_n), .clr(rd_rst[ch]),
            .adv(rfire[ch]), .last(AW'(DEPTH-1)), .ptr(rp_bc[ch-1]));
    end

    logic [AW-1:0] wlo0, rlo0;
    logic [1:0]    whi0, rhi0;
    assign wlo0 = wp0[AW-1:0];
    assign rlo0 = rp0[AW-1:0];
    assign whi0 = wp0[PW-1:AW];
    assign rhi0 = rp0[PW-1:AW];

    // chained stages write one cycle after the upstream read, from its register
    logic          chained, chain_pend;
    logic [AW-1:0] chain_addr;
    logic [1:0]    rsel;
    assign chained = (mode == MODE_CHAIN3) || (mode == MODE_CHAIN2_SPLIT1)
                  || (mode == MODE_WIDE_CHAIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_pend <= 1'b0;
            chain_addr <= '0;
            rsel       <= '0;
        end else begin
            chain_pend <= chained && rfire[0];
            chain_addr <= rlo0;
            if (rfire[0]) rsel <= rhi0;
        end
    end

    // slice ports: a (byte), bl/bh (nibbles of the middle bank), c (byte)
    logic          we_a, we_bl, we_bh, we_c, re_a, re_bl, re_bh, re_c;
    logic [AW-1:0] wa_a, wa_bl, wa_bh, wa_c, ra_a, ra_bl, ra_bh, ra_c;
    logic [BW-1:0] wd_a, wd_c, rd_a, rd_c;
    logic [HW-1:0] wd_bl, wd_bh, rd_bl, rd_bh;
    logic [3:0]    oe_next;

    always_comb begin
        {we_a, we_bl, we_bh, we_c, re_a, re_bl, re_bh, re_c} = '0;
        {wa_a, wa_bl, wa_bh, wa_c} = {4{wlo0}};
        {ra_a, ra_bl, ra_bh, ra_c} = {4{rlo0}};
        wd_a  = din_a;
        wd_bl = din_b[HW-1:0];
        wd_bh = din_b[BW-1:HW];
        wd_c  = din_c;
        oe_next = '0;
        unique case (mode)
            MODE_SPLIT3, MODE_CHAIN3, MODE_CHAIN2_SPLIT1: begin
                we_a = wfire[0];
                re_a = rfire[0];
                if (mode == MODE_SPLIT3) begin
                    {we_bl, we_bh} = {2{wfire[1]}};
                    {re_bl, re_bh} = {2{rfire[1]}};
                    {wa_bl, wa_bh} = {2{wp_bc[0]}};
                    {ra_bl, ra_bh} = {2{rp_bc[0]}};
                end else begin
                    {we_bl, we_bh} = {2{chain_pend}};
                    {re_bl, re_bh} = {2{rfire[0]}};
                    {wa_bl, wa_bh} = {2{chain_addr}};
                    wd_bl = rd_a[HW-1:0];
                    wd_bh = rd_a[BW-1:HW];
                end
                if (mode == MODE_CHAIN3) begin
                    we_c = chain_pend;
                    re_c = rfire[0];
                    wa_c = chain_addr;
                    wd_c = {rd_bh, rd_bl};
                    oe_next = {4{rfire[0]}};
                end else begin
                    we_c = wfire[2];
                    re_c = rfire[2];
                    wa_c = wp_bc[1];
                    ra_c = rp_bc[1];
                    oe_next = (mode == MODE_SPLIT3)
                            ? {rfire[2], rfire[1], rfire[1], rfire[0]}
                            : {rfire[2], rfire[0], rfire[0], rfire[0]};
                end
            end
            MODE_WIDE2, MODE_WIDE_CHAIN: begin
                {we_a, we_bl} = {2{wfire[0]}};
                {re_a, re_bl} = {2{rfire[0]}};
                if (mode == MODE_WIDE2) begin
                    {we_c, we_bh} = {2{wfire[1]}};
                    {re_c, re_bh} = {2{rfire[1]}};
                    {wa_c, wa_bh} = {2{wp_bc[0]}};
                    {ra_c, ra_bh} = {2{rp_bc[0]}};
                    oe_next = {rfire[1], rfire[1], rfire[0], rfire[0]};
                end else begin
                    {we_c, we_bh} = {2{chain_pend}};
                    {re_c, re_bh} = {2{rfire[0]}};
                    {wa_c, wa_bh} = {2{chain_addr}};
                    wd_c  = rd_a;
                    wd_bh = rd_bl;
                    oe_next = {4{rfire[0]}};
                end
            end
            MODE_DEEP3: begin
                we_a = wfire[0] && whi0 == 2'd0;
                re_a = rfire[0] && rhi0 == 2'd0;
                {we_bl, we_bh} = {2{wfire[0] && whi0 == 2'd1}};
                {re_bl, re_bh} = {2{rfire[0] && rhi0 == 2'd1}};
                we_c = wfire[0] && whi0 == 2'd2;
                re_c = rfire[0] && rhi0 == 2'd2;
                wd_bl = din_a[HW-1:0];
                wd_bh = din_a[BW-1:HW];
                wd_c  = din_a;
                oe_next = {3'b000, rfire[0]};
            end
            MODE_DEEP2_SPLIT1: begin
                we_a = wfire[0] && !whi0[0];
                re_a = rfire[0] && !rhi0[0];
                {we_bl, we_bh} = {2{wfire[0] && whi0[0]}};
                {re_bl, re_bh} = {2{rfire[0] && rhi0[0]}};
                wd_bl = din_a[HW-1:0];
                wd_bh = din_a[BW-1:HW];
                we_c = wfire[2];
                re_c = rfire[2];
                wa_c = wp_bc[1];
                ra_c = rp_bc[1];
                oe_next = {rfire[2], 2'b00, rfire[0]};
            end
            MODE_WIDE_DEEP: begin
                {we_a, we_bl} = {2{wfire[0] && !whi0[0]}};
                {re_a, re_bl} = {2{rfire[0] && !rhi0[0]}};
                {we_c, we_bh} = {2{wfire[0] && whi0[0]}};
                {re_c, re_bh} = {2{rfire[0] && rhi0[0]}};
                wd_c  = din_a;
                wd_bh = din_b[HW-1:0];
                oe_next = {2'b00, rfire[0], rfire[0]};
            end
        endcase
    end

    tfm_slice #(.W(BW), .DEPTH(DEPTH)) u_bank_a (.clk(clk), .we(we_a), .waddr(wa_a),
        .wdata(wd_a), .re(re_a), .raddr(ra_a), .rdata(rd_a));
    tfm_slice #(.W(HW), .DEPTH(DEPTH)) u_bank_bl (.clk(clk), .we(we_bl), .waddr(wa_bl),
        .wdata(wd_bl), .re(re_bl), .raddr(ra_bl), .rdata(rd_bl));
    tfm_slice #(.W(HW), .DEPTH(DEPTH)) u_bank_bh (.clk(clk), .we(we_bh), .waddr(wa_bh),
        .wdata(wd_bh), .re(re_bh), .raddr(ra_bh), .rdata(rd_bh));
    tfm_slice #(.W(BW), .DEPTH(DEPTH)) u_bank_c (.clk(clk), .we(we_c), .waddr(wa_c),
        .wdata(wd_c), .re(re_c), .raddr(ra_c), .rdata(rd_c));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_oe <= '0;
        else        lane_oe <= oe_next;
    end

    always_comb begin
        dout_a = rd_a;
        dout_b = {rd_bh, rd_bl};
        dout_c = rd_c;
        unique case (mode)
            MODE_DEEP3:        dout_a = rsel[1] ? rd_c : (rsel[0] ? {rd_bh, rd_bl} : rd_a);
            MODE_DEEP2_SPLIT1: dout_a = rsel[0] ? {rd_bh, rd_bl} : rd_a;
            MODE_WIDE_DEEP: begin
                dout_a = rsel[0] ? rd_c : rd_a;
                dout_b = {rd_bh, rsel[0] ? rd_bh : rd_bl};
            end
            default: ;
        endcase
    end

    p_lane_a_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en[0] && !rd_rst[0]) |=> lane_oe[0]);
    p_lane_a_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en[0] || rd_rst[0]) |=> !lane_oe[0]);
    p_deep_one_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEEP3) |-> $onehot0({re_a, re_bl, re_c}));
    p_unused_lanes_deep3_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEEP3) |=> lane_oe[3:1] == 3'b000);
    p_unused_lanes_wide_deep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIDE_DEEP) |=> lane_oe[3:2] == 2'b00);
endmodule

// File: tb/tri_field_mem_test.sv
`timescale 1ns/1ps
module tri_field_mem_test;
    localparam int D  = 16;
    localparam int MD = 3 * D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic [2:0] wr_en = '0, wr_rst = '0, rd_en = '0, rd_rst = '0;
    logic [7:0] din_a = '0, din_b = '0, din_c = '0;
    logic [7:0] dout_a, dout_b, dout_c;
    logic [3:0] lane_oe;

    always #5 clk = ~clk;

    tri_field_mem #(.DEPTH(D), .BW(8)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_rst(wr_rst), .rd_en(rd_en), .rd_rst(rd_rst),
        .din_a(din_a), .din_b(din_b), .din_c(din_c),
        .dout_a(dout_a), .dout_b(dout_b), .dout_c(dout_c), .lane_oe(lane_oe));

    int    nchk = 0, nerr = 0;
    string cur_tag = "R10";
    bit    done = 0;

    // behavioural model: up to three logical channels
    bit          act [3];
    int          len [3], ctl [3], casc [3];
    bit          wide;
    logic [11:0] mem [3][MD];
    bit          mv  [3][MD];
    int          wp [3], rp [3];
    logic [11:0] outv [3];
    bit          ov [3], oe [3];

    task automatic chk(input bit ok, input string what, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s got %h exp %h", cur_tag, what, got, exp);
        end
    endtask

    function automatic logic [11:0] ch_in(int c);
        if (wide) return (c == 0) ? {din_a, din_b[3:0]} : {din_c, din_b[7:4]};
        case (ctl[c])
            0:       return {4'h0, din_a};
            1:       return {4'h0, din_b};
            default: return {4'h0, din_c};
        endcase
    endfunction

    task automatic cfg_model(input logic [2:0] m);
        for (int c = 0; c < 3; c++) begin
            act[c] = (c == 0); len[c] = D; ctl[c] = c; casc[c] = -1;
            for (int i = 0; i < MD; i++) mv[c][i] = 0;
        end
        wide = 0;
        case (m)
            3'd0: begin act[1] = 1; act[2] = 1; end
            3'd1: begin act[1] = 1; act[2] = 1; casc[1] = 0; casc[2] = 1; end
            3'd2: begin act[1] = 1; act[2] = 1; casc[1] = 0; end
            3'd3: begin wide = 1; act[1] = 1; end
            3'd4: begin wide = 1; act[1] = 1; casc[1] = 0; end
            3'd5: len[0] = 3 * D;
            3'd6: begin len[0] = 2 * D; act[2] = 1; end
            default: begin wide = 1; len[0] = 2 * D; end
        endcase
    endtask

    task automatic model_step();
        int arp;
        bit fa;
        arp = rp[0];
        fa  = rd_en[0] && !rd_rst[0];
        for (int c = 0; c < 3; c++) begin
            if (act[c] && casc[c] < 0) begin
                if (rd_rst[ctl[c]]) begin rp[c] = 0; oe[c] = 0; end
                else if (rd_en[ctl[c]]) begin
                    outv[c] = mem[c][rp[c]]; ov[c] = mv[c][rp[c]]; oe[c] = 1;
                    rp[c] = (rp[c] + 1) % len[c];
                end else oe[c] = 0;
                if (wr_rst[ctl[c]]) wp[c] = 0;
                else if (wr_en[ctl[c]]) begin
                    mem[c][wp[c]] = ch_in(c); mv[c][wp[c]] = 1;
                    wp[c] = (wp[c] + 1) % len[c];
                end
            end else if (act[c]) begin
                if (fa) begin
                    outv[c] = mem[c][arp]; ov[c] = mv[c][arp]; oe[c] = 1;
                    mem[c][arp] = outv[casc[c]]; mv[c][arp] = ov[casc[c]];
                end else oe[c] = 0;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin wp[c] = 0; rp[c] = 0; oe[c] = 0; ov[c] = 0; end
        end else model_step();
    end

    task automatic compare();
        logic [3:0] e;
        if (!wide) e = {act[2] & oe[2], act[1] & oe[1], act[1] & oe[1], oe[0]};
        else       e = {act[1] & oe[1], act[1] & oe[1], oe[0], oe[0]};
        chk(lane_oe == e, "lane_oe", {12'h0, lane_oe}, {12'h0, e});
        if (!wide) begin
            if (oe[0] && ov[0]) chk(dout_a == outv[0][7:0], "dout_a", {8'h0, dout_a}, {8'h0, outv[0][7:0]});
            if (act[1] && oe[1] && ov[1]) chk(dout_b == outv[1][7:0], "dout_b", {8'h0, dout_b}, {8'h0, outv[1][7:0]});
            if (act[2] && oe[2] && ov[2]) chk(dout_c == outv[2][7:0], "dout_c", {8'h0, dout_c}, {8'h0, outv[2][7:0]});
        end else begin
            if (oe[0] && ov[0]) chk({dout_a, dout_b[3:0]} == outv[0], "word0", {4'h0, dout_a, dout_b[3:0]}, {4'h0, outv[0]});
            if (act[1] && oe[1] && ov[1]) chk({dout_c, dout_b[7:4]} == outv[1], "word1", {4'h0, dout_c, dout_b[7:4]}, {4'h0, outv[1]});
        end
    endtask

    task automatic run_phase(input logic [2:0] m, input string tag, input int ncyc,
                             input int pw, input int pr, input int prst);
        @(negedge clk);
        rst_n = 0; mode_sel = m; wr_en = '0; wr_rst = '0; rd_en = '0; rd_rst = '0;
        cfg_model(m);
        @(negedge clk);
        cur_tag = "R10";
        chk(lane_oe == 4'h0, "lane_oe in reset", {12'h0, lane_oe}, 16'h0);
        @(negedge clk);
        rst_n = 1;
        cur_tag = tag;
        for (int i = 0; i < ncyc; i++) begin
            for (int k = 0; k < 3; k++) begin
                wr_en[k]  = ($urandom % 100) < pw;
                rd_en[k]  = ($urandom % 100) < pr;
                wr_rst[k] = ($urandom % 100) < prst;
                rd_rst[k] = ($urandom % 100) < prst;
            end
            din_a = 8'($urandom); din_b = 8'($urandom); din_c = 8'($urandom);
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        run_phase(3'd0, "R2",  300, 90, 40, 0);
        run_phase(3'd0, "R3",  400, 60, 60, 5);
        run_phase(3'd0, "R11", 200, 100, 100, 0);
        run_phase(3'd0, "R5",  400, 50, 50, 2);
        run_phase(3'd1, "R6",  500, 70, 70, 2);
        run_phase(3'd2, "R1",  500, 70, 70, 2);
        run_phase(3'd3, "R7",  400, 60, 60, 2);
        run_phase(3'd4, "R6",  500, 70, 70, 2);
        run_phase(3'd5, "R8",  600, 60, 60, 1);
        run_phase(3'd6, "R4",  600, 60, 60, 1);
        run_phase(3'd7, "R9",  600, 60, 60, 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog %s got timeout exp completion", cur_tag);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule